// File: doc/BRIEF.md
# Converter sample timing controller

This block sets the timing of one sample period for a serial analog-to-digital converter (ADC) and a serial digital-to-analog converter (DAC). A rate divider built from two build-time frequencies produces one sampling tick each period. Each tick starts a four-state sequence: idle, acquire, done and output. During acquire, the ADC chip select and read enable are high. When the ADC interface reports that conversion is complete, the block takes the sample, gives a one-cycle sample-done strobe and toggles the DAC frame-sync line. It then holds the DAC write enable high until the DAC interface reports that it has finished.

The DAC frame sync does not follow the sampling tick. The end of acquisition releases it, so output always comes after a completed input capture. Each sample-done event advances two serial-in parallel-out delay lines by exactly one place. The first line holds the most recent input samples. The second holds the most recent filter results. Both lines show every tap in parallel to a filter engine.

A tick can arrive while a sequence is still running. The block holds that tick as pending and starts the next acquisition straight after the current output has finished, so no sample period is lost.

Top module: `conv_sample_ctrl`

## Requirements
- R1: While rst_ni is low, adc_cs_o, adc_rd_en_o, dac_wr_en_o, dac_sync_o and smp_done_o are 0, and all taps of x_taps_o and y_taps_o are 0.
- R2: A sampling tick occurs every DIV = CLK_HZ/SAMPLE_HZ clocks. The first tick falls in the cycle before clock edge DIV after reset. adc_cs_o and adc_rd_en_o go high on the edge after a tick that finds the block idle. They drop on the edge after adc_done_i is seen high during acquisition.
- R3: adc_rd_en_o and dac_wr_en_o are never high together. dac_wr_en_o goes high on the edge after smp_done_o. It stays high up to and including the cycle in which dac_done_i is seen high, then drops.
- R4: smp_done_o is a single-cycle pulse in the cycle after adc_done_i is accepted. dac_sync_o toggles on the edge that ends that pulse and on no other edge.
- R5: At each sample-done event, x_taps_o shifts by one tap. Tap k sits at bits [k*W +: W]. Tap 0 takes the value that adc_data_i had in the cycle when adc_done_i was accepted, and tap k takes the old tap k-1.
- R6: y_taps_o shifts on the same events in the same layout. Tap 0 takes the value that filt_data_i has during the smp_done_o cycle.
- R7: Neither delay line changes outside a sample-done event. adc_done_i has no effect outside acquisition, and dac_done_i has no effect outside output.
- R8: A tick that arrives while the block is not idle is held pending. After the sequence returns to idle for one cycle, the next edge starts acquisition again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adc_done_i | input | 1 | ADC interface reports that conversion is complete |
| adc_data_i | input | W | Converted sample, valid together with adc_done_i |
| dac_done_i | input | 1 | DAC interface reports that the word has been sent |
| filt_data_i | input | W | Filter result to store in the output delay line |
| adc_cs_o | output | 1 | ADC chip select, high during acquisition |
| adc_rd_en_o | output | 1 | Read enable to the ADC interface |
| dac_wr_en_o | output | 1 | Write enable to the DAC interface |
| dac_sync_o | output | 1 | DAC frame-sync line, toggled once per sample |
| smp_done_o | output | 1 | Sample-done strobe to the filter engine |
| x_taps_o | output | TAPS*W | Input sample delay line, tap 0 newest |
| y_taps_o | output | TAPS*W | Filter result delay line, tap 0 newest |

## Verification
The sequence runs with short acquire and output phases, where the cycle count between chip-select rises must equal the divider period. It also runs with zero-length waits, which show that an acquisition of a single cycle still completes. Two long phases are tried: a long acquisition and a long output. Each lets a tick land while the block is busy, which separates a pending start from a lost period. Done pulses arriving in the idle and output states, and garbage data driven after capture, show whether the delay lines respond to anything other than a genuine sample-done event and whether they take the right data word.

// File: rtl/conv_smp_pkg.sv
package conv_smp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACQUIRE = 2'd1,
    ST_DONE    = 2'd2,
    ST_OUTPUT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/conv_rate_tick.sv
module conv_rate_tick #(
  parameter int unsigned DIV = 1133
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_smp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic adc_done_i,
  input  logic dac_done_i,
  output logic cap_o,
  output logic adc_cs_o,
  output logic rd_en_o,
  output logic wr_en_o,
  output logic done_o,
  output logic sync_o
);
  seq_state_e state_q, state_d;
  logic pend_q, sync_q;
  logic start;

  assign start = (state_q == ST_IDLE) && (tick_i || pend_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_ACQUIRE;
      ST_ACQUIRE: if (adc_done_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_OUTPUT;
      ST_OUTPUT:  if (dac_done_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // tick while busy is held for one later start
      if (start)       pend_q <= 1'b0;
      else if (tick_i) pend_q <= 1'b1;
      if (state_q == ST_DONE) sync_q <= ~sync_q;
    end
  end

  assign cap_o    = (state_q == ST_ACQUIRE) && adc_done_i;
  assign adc_cs_o = (state_q == ST_ACQUIRE);
  assign rd_en_o  = (state_q == ST_ACQUIRE);
  assign wr_en_o  = (state_q == ST_OUTPUT);
  assign done_o   = (state_q == ST_DONE);
  assign sync_o   = sync_q;

  AST_CS_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && tick_i) |=> adc_cs_o); // R2
  AST_EN_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !adc_cs_o); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && wr_en_o); // R4
  AST_SYNC_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (sync_o != $past(sync_o))); // R4
  AST_SYNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(sync_o)); // R4
  AST_PEND_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && pend_q) |=> adc_cs_o); // R8
endmodule

// File: rtl/conv_sipo_line.sv
module conv_sipo_line #(
  parameter int unsigned W    = 16,
  parameter int unsigned TAPS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [W-1:0]      din_i,
  output logic [TAPS*W-1:0] taps_o
);
  logic [W-1:0] tap_q [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [W-1:0] src;
    if (k == 0) begin : g_head
      assign src = din_i;
    end else begin : g_body
      assign src = tap_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tap_q[k] <= '0;
      else if (shift_i) tap_q[k] <= src;
    end
    assign taps_o[k*W +: W] = tap_q[k];
  end
endmodule

// File: rtl/conv_sample_ctrl.sv
module conv_sample_ctrl #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SAMPLE_HZ = 44_100,
  parameter int unsigned W         = 16,
  parameter int unsigned TAPS      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adc_done_i,
  input  logic [W-1:0]      adc_data_i,
  input  logic              dac_done_i,
  input  logic [W-1:0]      filt_data_i,
  output logic              adc_cs_o,
  output logic              adc_rd_en_o,
  output logic              dac_wr_en_o,
  output logic              dac_sync_o,
  output logic              smp_done_o,
  output logic [TAPS*W-1:0] x_taps_o,
  output logic [TAPS*W-1:0] y_taps_o
);
  localparam int unsigned DIV = CLK_HZ / SAMPLE_HZ;

  logic         tick, cap;
  logic [W-1:0] sample_q;

  conv_rate_tick #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  conv_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .adc_done_i (adc_done_i),
    .dac_done_i (dac_done_i),
    .cap_o      (cap),
    .adc_cs_o   (adc_cs_o),
    .rd_en_o    (adc_rd_en_o),
    .wr_en_o    (dac_wr_en_o),
    .done_o     (smp_done_o),
    .sync_o     (dac_sync_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sample_q <= '0;
    else if (cap) sample_q <= adc_data_i;
  end

  conv_sipo_line #(.W(W), .TAPS(TAPS)) u_xline (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (smp_done_o),
    .din_i   (sample_q),
    .taps_o  (x_taps_o)
  );

  conv_sipo_line #(.W(W), .TAPS(TAPS)) u_yline (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (smp_done_o),
    .din_i   (filt_data_i),
    .taps_o  (y_taps_o)
  );

  AST_TAPS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_done_o |=> ($stable(x_taps_o) && $stable(y_taps_o))); // R7
  AST_NEWEST_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> ##1 (x_taps_o[W-1:0] == $past(adc_data_i, 2))); // R5
  AST_NEWEST_Y: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_done_o |=> (y_taps_o[W-1:0] == $past(filt_data_i))); // R6
endmodule

// File: tb/conv_sample_ctrl_tb_top.sv
module conv_sample_ctrl_tb_top;
  localparam int unsigned CLK_HZ = 1200, SAMPLE_HZ = 100, W = 8, TAPS = 4;
  localparam int unsigned DIV = CLK_HZ / SAMPLE_HZ;
  localparam int NV = 9;
  // adc, filt, acquire wait, output wait, flags {poke, pend, gap}
  localparam logic [39:0] VEC [NV] = '{
    {8'h11, 8'hA1, 8'd1,  8'd1,  8'd0},
    {8'h22, 8'hB2, 8'd1,  8'd2,  8'd1},
    {8'h33, 8'hC3, 8'd0,  8'd0,  8'd1},
    {8'h44, 8'hD4, 8'd2,  8'd1,  8'd5},
    {8'h55, 8'hE5, 8'd14, 8'd1,  8'd3},
    {8'h66, 8'hF6, 8'd1,  8'd14, 8'd2},
    {8'h77, 8'h07, 8'd0,  8'd3,  8'd0},
    {8'h88, 8'h18, 8'd1,  8'd0,  8'd0},
    {8'h99, 8'h29, 8'd2,  8'd1,  8'd1}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic adc_done_i = 1'b0, dac_done_i = 1'b0;
  logic [W-1:0] adc_data_i = '0, filt_data_i = '0;
  logic adc_cs_o, adc_rd_en_o, dac_wr_en_o, dac_sync_o, smp_done_o;
  logic [TAPS*W-1:0] x_taps_o, y_taps_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  conv_sample_ctrl #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .W(W), .TAPS(TAPS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .adc_done_i(adc_done_i), .adc_data_i(adc_data_i),
    .dac_done_i(dac_done_i), .filt_data_i(filt_data_i),
    .adc_cs_o(adc_cs_o), .adc_rd_en_o(adc_rd_en_o), .dac_wr_en_o(dac_wr_en_o),
    .dac_sync_o(dac_sync_o), .smp_done_o(smp_done_o),
    .x_taps_o(x_taps_o), .y_taps_o(y_taps_o)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: cycles=20000 expected=fewer");
    summary();
  end

  initial begin
    logic [TAPS*W-1:0] x_mdl, y_mdl;
    logic sync_prev;
    int last_rise;
    x_mdl = '0;
    y_mdl = '0;
    repeat (3) @(negedge clk);
    check({adc_cs_o, adc_rd_en_o, dac_wr_en_o, dac_sync_o, smp_done_o} == 5'b0,
          "R1 control outputs in reset",
          {adc_cs_o, adc_rd_en_o, dac_wr_en_o, dac_sync_o, smp_done_o}, 0);
    check(x_taps_o == '0 && y_taps_o == '0, "R1 taps in reset", {x_taps_o, y_taps_o}, 0);
    rst_ni = 1'b1;
    // stray done pulses while idle
    @(negedge clk);
    adc_done_i = 1'b1; dac_done_i = 1'b1; adc_data_i = 8'hEE;
    @(negedge clk);
    adc_done_i = 1'b0; dac_done_i = 1'b0;
    check(!smp_done_o && !adc_cs_o && !dac_wr_en_o, "R7 done pulses in idle ignored",
          {smp_done_o, adc_cs_o, dac_wr_en_o}, 0);
    @(negedge clk);
    check(x_taps_o == '0 && y_taps_o == '0, "R7 taps after idle pulses", {x_taps_o, y_taps_o}, 0);
    while (adc_cs_o !== 1'b1) @(negedge clk);
    check(cyc == DIV, "R2 first chip select edge", cyc, DIV);
    last_rise = cyc;

    for (int r = 0; r < NV; r++) begin
      logic [7:0] a_v, f_v, a_dly, d_dly, flg;
      int n_out;
      {a_v, f_v, a_dly, d_dly, flg} = VEC[r];
      while (adc_cs_o !== 1'b1) @(negedge clk);
      if (flg[0]) check(cyc - last_rise == DIV, "R2 tick period", cyc - last_rise, DIV);
      last_rise = cyc;
      check(adc_rd_en_o && !dac_wr_en_o, "R3 read enable only in acquire",
            {adc_rd_en_o, dac_wr_en_o}, 2'b10);
      repeat (a_dly) @(negedge clk);
      check(adc_cs_o, "R2 chip select held until done", adc_cs_o, 1);
      adc_data_i = a_v; filt_data_i = f_v; adc_done_i = 1'b1;
      sync_prev = dac_sync_o;
      @(negedge clk);
      adc_done_i = 1'b0; adc_data_i = 8'h5A;
      check(smp_done_o && !adc_cs_o, "R4 sample-done pulse, R2 cs dropped",
            {smp_done_o, adc_cs_o}, 2'b10);
      x_mdl = {x_mdl[(TAPS-1)*W-1:0], a_v};
      y_mdl = {y_mdl[(TAPS-1)*W-1:0], f_v};
      @(negedge clk);
      check(dac_wr_en_o && !adc_rd_en_o && !smp_done_o, "R3 write enable after done",
            {dac_wr_en_o, adc_rd_en_o, smp_done_o}, 3'b100);
      check(dac_sync_o == ~sync_prev, "R4 frame sync toggled", dac_sync_o, ~sync_prev);
      check(x_taps_o == x_mdl, "R5 input delay line", x_taps_o, x_mdl);
      check(y_taps_o == y_mdl, "R6 output delay line", y_taps_o, y_mdl);
      n_out = d_dly;
      if (flg[2]) begin
        adc_done_i = 1'b1; adc_data_i = 8'hFF;
        @(negedge clk);
        adc_done_i = 1'b0;
        check(!smp_done_o && dac_wr_en_o && x_taps_o == x_mdl,
              "R7 adc done in output ignored", x_taps_o, x_mdl);
        n_out = d_dly - 1;
      end
      repeat (n_out) @(negedge clk);
      check(dac_wr_en_o, "R3 write enable held", dac_wr_en_o, 1);
      dac_done_i = 1'b1;
      @(negedge clk);
      dac_done_i = 1'b0;
      check(!dac_wr_en_o && dac_sync_o == ~sync_prev, "R3 write enable released, R4 sync held",
            {dac_wr_en_o, dac_sync_o}, {1'b0, ~sync_prev});
      if (flg[1]) begin
        @(negedge clk);
        check(adc_cs_o, "R8 pending tick starts acquire", adc_cs_o, 1);
      end
    end

    // asynchronous reset in the middle of a sequence
    while (adc_cs_o !== 1'b1) @(negedge clk);
    #1 rst_ni = 1'b0;
    #1;
    check(!adc_cs_o && x_taps_o == '0 && y_taps_o == '0 && !dac_sync_o,
          "R1 mid-run reset clears state", {adc_cs_o, x_taps_o}, 0);
    summary();
  end
endmodule